// File: doc/BRIEF.md
# Input Capture Noise Filter

This block is the front end of a four-channel timer capture unit. Every channel takes an asynchronous input pin, brings it into the bus clock domain through a two-stage synchroniser, and cleans it with a programmable digital noise filter. A per-channel edge detector watches the filtered level. When the chosen edge appears, the detector copies the free-running timer count into that channel's capture register and raises a sticky capture flag. An enable bit for each channel controls whether that flag reaches the shared interrupt line.

A 2-bit divider setting derives a filter-clock enable from the bus clock. A 4-bit code per channel then does two things: it picks the sample strobe, which is either the bus clock itself or the filter clock divided by 2, 4, 8, 16 or 32, and it picks how many consecutive agreeing samples are needed before the filtered level may change. Code zero turns the filter off. The timer counter and the register access path are outside the block.

Top module: `icf_capture_top`

## Requirements
- R1: The input passes through a two-flop synchroniser. With code 0 (bypass), a level applied before clock edge k is registered as the filtered level at edge k+2. If that level forms the selected edge, the capture register and flag update at edge k+3, and the register holds the counter value present at that edge.
- R2: `div_sel` sets the filter clock enable. Values 00 and 11 enable it on every cycle. Value 01 enables it on every second cycle and value 10 on every fourth. A free-running counter of filter-clock enables then produces the slower sample strobes.
- R3: Codes 1, 2 and 3 take a sample on every bus clock and need 2, 4 and 8 consecutive samples at the new level, respectively.
- R4: Codes 4 and 5 sample at the filter clock divided by 2, codes 6 and 7 divide it by 4, and codes 8 and 9 divide it by 8. In each pair the even code needs 6 samples and the odd code needs 8.
- R5: Codes 10, 11 and 12 sample at the filter clock divided by 16. Codes 13, 14 and 15 sample at the filter clock divided by 32. Within each group of three, the codes need 5, 6 and 8 samples in that order.
- R6: A sample that matches the current filtered level resets the run count to zero. A pulse shorter than the required run therefore changes neither the filtered level nor the capture outputs.
- R7: `edge_fall` bit = 0 captures on a rising filtered edge and bit = 1 captures on a falling one. An edge in the other direction has no effect on the flag or the register.
- R8: A capture sets the channel's flag. The flag stays set until a cycle in which `flag_clr` is high and no new capture happens; a capture in the same cycle as a clear wins. The capture register changes only on a capture.
- R9: `irq` is high exactly when at least one channel has its flag set and its `irq_en` bit high.
- R10: After reset, every flag, every capture register and `irq` read zero, and every filtered level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NCH | Asynchronous capture inputs, one per channel |
| div_sel | input | 2 | Filter clock divider select |
| flt_code | input | 4*NCH | Filter code per channel, channel g at bits 4g+3..4g |
| edge_fall | input | NCH | Edge select per channel: 0 rising, 1 falling |
| irq_en | input | NCH | Interrupt enable per channel |
| flag_clr | input | NCH | Flag clear per channel, level sensitive |
| cnt_val | input | CW | Running timer count to be captured |
| cap_val | output | CW*NCH | Capture registers, channel g at bits CW*g+CW-1..CW*g |
| cap_flag | output | NCH | Sticky capture flags |
| irq | output | 1 | Combined masked capture interrupt |

## Verification
In bypass, a captured value and its flag show up three edges after the input change, and the bench checks both results at the falling clock edge right after that third edge. It also checks one edge earlier to confirm nothing has appeared too soon. With the filter active, the delay depends on the code, the divider setting and the phase of the divided strobes. The behavioural model in the bench therefore keeps its own phase counters, and every cycle it compares the flags, the capture registers and the interrupt against the design at the falling edge. The interrupt is combinational, so it is compared in the same cycle as the flags that drive it.

// File: rtl/icf_pkg.sv
package icf_pkg;
   localparam int unsigned CODE_W    = 4;
   localparam int unsigned MAX_SHIFT = 5;
   localparam int unsigned RUN_W     = 4;
   localparam int unsigned SHIFT_W   = 3;

   typedef enum logic [1:0] {
      FDIV_ONE     = 2'b00,
      FDIV_TWO     = 2'b01,
      FDIV_FOUR    = 2'b10,
      FDIV_ONE_ALT = 2'b11
   } fdiv_e;

   typedef struct packed {
      logic               bypass;
      logic [SHIFT_W-1:0] shift;  // 0: bus clock, s: filter clock / 2**s
      logic [RUN_W-1:0]   need;   // agreeing samples required
   } flt_cfg_t;

   function automatic flt_cfg_t decode_flt(input logic [CODE_W-1:0] code);
      flt_cfg_t c;
      c.bypass = 1'b0;
      c.shift  = '0;
      c.need   = RUN_W'(1);
      unique case (code)
         4'd0:  c.bypass = 1'b1;
         4'd1:  c.need = RUN_W'(2);
         4'd2:  c.need = RUN_W'(4);
         4'd3:  c.need = RUN_W'(8);
         4'd4:  begin c.shift = 3'd1; c.need = RUN_W'(6); end
         4'd5:  begin c.shift = 3'd1; c.need = RUN_W'(8); end
         4'd6:  begin c.shift = 3'd2; c.need = RUN_W'(6); end
         4'd7:  begin c.shift = 3'd2; c.need = RUN_W'(8); end
         4'd8:  begin c.shift = 3'd3; c.need = RUN_W'(6); end
         4'd9:  begin c.shift = 3'd3; c.need = RUN_W'(8); end
         4'd10: begin c.shift = 3'd4; c.need = RUN_W'(5); end
         4'd11: begin c.shift = 3'd4; c.need = RUN_W'(6); end
         4'd12: begin c.shift = 3'd4; c.need = RUN_W'(8); end
         4'd13: begin c.shift = 3'd5; c.need = RUN_W'(5); end
         4'd14: begin c.shift = 3'd5; c.need = RUN_W'(6); end
         default: begin c.shift = 3'd5; c.need = RUN_W'(8); end
      endcase
      return c;
   endfunction
endpackage

// File: rtl/icf_rate_gen.sv
module icf_rate_gen
   import icf_pkg::*;
#(
   parameter int unsigned NSTRB = MAX_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       div_sel,
   output logic [NSTRB-1:0] smp_en
);
   localparam int unsigned FCW = NSTRB - 1;

   if (NSTRB < 2) begin : g_bad_nstrb
      $error("icf_rate_gen: NSTRB must be at least 2");
   end

   logic [1:0]     pre_q;
   logic [FCW-1:0] fcnt_q;
   logic           fdts_en;

   always_comb begin
      unique case (fdiv_e'(div_sel))
         FDIV_TWO:  fdts_en = pre_q[0];
         FDIV_FOUR: fdts_en = &pre_q;
         default:   fdts_en = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         fcnt_q <= '0;
      end else begin
         pre_q <= pre_q + 2'd1;
         if (fdts_en) fcnt_q <= fcnt_q + FCW'(1);
      end
   end

   assign smp_en[0] = 1'b1;
   for (genvar k = 1; k < NSTRB; k++) begin : g_strb
      assign smp_en[k] = fdts_en & (&fcnt_q[k-1:0]);
   end
endmodule

// File: rtl/icf_noise_filter.sv
module icf_noise_filter
   import icf_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NSTRB       = MAX_SHIFT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [NSTRB-1:0]  smp_en_i,
   output logic              filt_o
);
   localparam int unsigned PADW = 1 << SHIFT_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icf_noise_filter: SYNC_STAGES must be at least 2");
   end
   if (NSTRB > PADW) begin : g_bad_strb
      $error("icf_noise_filter: NSTRB exceeds shift range");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   flt_cfg_t               cfg;
   logic [PADW-1:0]        en_pad;
   logic                   smp;
   logic [RUN_W-1:0]       run_q;
   logic [RUN_W-1:0]       run_nxt;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   assign cfg     = decode_flt(code_i);
   assign en_pad  = PADW'(smp_en_i);
   assign smp     = en_pad[cfg.shift];
   assign run_nxt = run_q + RUN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         run_q  <= '0;
      end else if (cfg.bypass) begin
         filt_q <= synced;
         run_q  <= '0;
      end else if (smp) begin
         if (synced == filt_q) begin
            run_q <= '0;
         end else if (run_nxt >= cfg.need) begin
            filt_q <= synced;
            run_q  <= '0;
         end else begin
            run_q <= run_nxt;
         end
      end
   end

   assign filt_o = filt_q;
endmodule

// File: rtl/icf_capture.sv
module icf_capture #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          filt_i,
   input  logic          fall_i,
   input  logic          clr_i,
   input  logic [CW-1:0] cnt_i,
   output logic [CW-1:0] cap_o,
   output logic          flag_o
);
   logic prev_q;
   logic hit;

   assign hit = fall_i ? (prev_q & ~filt_i) : (~prev_q & filt_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cap_o  <= '0;
         flag_o <= 1'b0;
      end else begin
         prev_q <= filt_i;
         if (hit) begin
            cap_o  <= cnt_i;
            flag_o <= 1'b1;
         end else if (clr_i) begin
            flag_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/icf_capture_top.sv
module icf_capture_top
   import icf_pkg::*;
#(
   parameter int unsigned NCH         = 4,
   parameter int unsigned CW          = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    cap_in,
   input  logic [1:0]        div_sel,
   input  logic [NCH*4-1:0]  flt_code,
   input  logic [NCH-1:0]    edge_fall,
   input  logic [NCH-1:0]    irq_en,
   input  logic [NCH-1:0]    flag_clr,
   input  logic [CW-1:0]     cnt_val,
   output logic [NCH*CW-1:0] cap_val,
   output logic [NCH-1:0]    cap_flag,
   output logic              irq
);
   localparam int unsigned NSTRB = MAX_SHIFT + 1;

   if (NCH < 1) begin : g_bad_nch
      $error("icf_capture_top: NCH must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("icf_capture_top: CW must be at least 1");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("icf_capture_top: filter code must be 4 bits");
   end

   logic [NSTRB-1:0] smp_en;

   icf_rate_gen #(.NSTRB(NSTRB)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .smp_en  (smp_en)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic filt;

      icf_noise_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .NSTRB       (NSTRB)
      ) u_flt (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_i    (cap_in[g]),
         .code_i   (flt_code[g*CODE_W +: CODE_W]),
         .smp_en_i (smp_en),
         .filt_o   (filt)
      );

      icf_capture #(.CW(CW)) u_cap (
         .clk    (clk),
         .rst_n  (rst_n),
         .filt_i (filt),
         .fall_i (edge_fall[g]),
         .clr_i  (flag_clr[g]),
         .cnt_i  (cnt_val),
         .cap_o  (cap_val[g*CW +: CW]),
         .flag_o (cap_flag[g])
      );
   end

   assign irq = |(cap_flag & irq_en);
endmodule

// File: rtl/icf_checker.sv
module icf_checker #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    cap_in,
   input logic [NCH*4-1:0]  flt_code,
   input logic [NCH-1:0]    edge_fall,
   input logic [NCH-1:0]    flag_clr,
   input logic [NCH*CW-1:0] cap_val,
   input logic [NCH-1:0]    cap_flag,
   input logic              irq
);
   logic [2:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cyc_q <= '0;
      else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R1: in bypass, a new rising capture reflects the input four ticks back
      p_bypass_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc_q >= 3'd5) && $rose(cap_flag[i]) &&
         ($past(flt_code[i*4 +: 4], 2) == 4'd0) && !$past(edge_fall[i])
         |-> $past(cap_in[i], 4));

      // R8: a set flag is held unless cleared
      p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cap_flag[i] && !flag_clr[i] |=> cap_flag[i]);

      // R8: the capture register only moves on a capture
      p_cap_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(cap_val[i*CW +: CW]) |-> cap_flag[i]);
   end

   // R9: no flag, no interrupt
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag == '0) |-> !irq);
endmodule

bind icf_capture_top icf_checker #(.NCH(NCH), .CW(CW)) u_icf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cap_in    (cap_in),
   .flt_code  (flt_code),
   .edge_fall (edge_fall),
   .flag_clr  (flag_clr),
   .cap_val   (cap_val),
   .cap_flag  (cap_flag),
   .irq       (irq)
);

// File: tb/test_icf_capture_top.sv
`timescale 1ns/1ps
module test_icf_capture_top;
   localparam int  NCH  = 4;
   localparam int  CW   = 16;
   localparam time TCLK = 20ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    cap_in = '0;
   logic [1:0]        div_sel = 2'b00;
   logic [NCH*4-1:0]  flt_code = '0;
   logic [NCH-1:0]    edge_fall = '0;
   logic [NCH-1:0]    irq_en = '0;
   logic [NCH-1:0]    flag_clr = '0;
   logic [CW-1:0]     cnt_val = '0;
   logic [NCH*CW-1:0] cap_val;
   logic [NCH-1:0]    cap_flag;
   logic              irq;

   icf_capture_top #(.NCH(NCH), .CW(CW)) i_icf_capture_top (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .div_sel(div_sel),
      .flt_code(flt_code), .edge_fall(edge_fall), .irq_en(irq_en),
      .flag_clr(flag_clr), .cnt_val(cnt_val), .cap_val(cap_val),
      .cap_flag(cap_flag), .irq(irq)
   );

   always #(TCLK/2) clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   string tag = "R10";
   bit    done = 1'b0;

   // behavioural reference state
   int m_s1[NCH], m_s2[NCH], m_filt[NCH], m_prev[NCH], m_run[NCH], m_cap[NCH];
   int m_flag[NCH];
   int m_pre, m_fc;

   function automatic int shift_of(int c);
      if (c <= 3) return 0;
      if (c <= 9) return (c - 2) / 2;
      if (c <= 12) return 4;
      return 5;
   endfunction

   function automatic int need_of(int c);
      int tbl[3] = '{5, 6, 8};
      if (c <= 3) return 1 << c;
      if (c <= 9) return (c % 2 == 0) ? 6 : 8;
      return tbl[(c - 10) % 3];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_filt[i] = 0; m_prev[i] = 0;
            m_run[i] = 0; m_cap[i] = 0; m_flag[i] = 0;
         end
         m_pre = 0; m_fc = 0;
      end else begin : step_model
         bit fd;
         fd = (div_sel == 2'b01) ? (m_pre % 2 == 1) :
              (div_sel == 2'b10) ? (m_pre == 3) : 1'b1;
         for (int i = 0; i < NCH; i++) begin
            int c, s, n;
            bit en, hit;
            c = int'(flt_code[i*4 +: 4]);
            s = shift_of(c);
            n = need_of(c);
            en = (s == 0) || (fd && ((m_fc % (1 << s)) == (1 << s) - 1));
            hit = edge_fall[i] ? (m_prev[i] == 1 && m_filt[i] == 0)
                               : (m_prev[i] == 0 && m_filt[i] == 1);
            if (hit) begin
               m_cap[i] = int'(cnt_val);
               m_flag[i] = 1;
            end else if (flag_clr[i]) begin
               m_flag[i] = 0;
            end
            m_prev[i] = m_filt[i];
            if (c == 0) begin
               m_filt[i] = m_s2[i];
               m_run[i] = 0;
            end else if (en) begin
               if (m_s2[i] == m_filt[i]) m_run[i] = 0;
               else if (m_run[i] + 1 >= n) begin
                  m_filt[i] = m_s2[i];
                  m_run[i] = 0;
               end else m_run[i] = m_run[i] + 1;
            end
            m_s2[i] = m_s1[i];
            m_s1[i] = int'(cap_in[i]);
         end
         m_pre = (m_pre + 1) % 4;
         if (fd) m_fc = (m_fc + 1) % 32;
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int mirq;
         mirq = 0;
         for (int i = 0; i < NCH; i++) begin
            chk(cap_flag[i] == m_flag[i][0], tag, $sformatf("flag ch%0d", i),
                cap_flag[i], m_flag[i]);
            chk(int'(cap_val[i*CW +: CW]) == m_cap[i], tag, $sformatf("cap ch%0d", i),
                cap_val[i*CW +: CW], m_cap[i]);
            if (m_flag[i] != 0 && irq_en[i]) mirq = 1;
         end
         chk(irq == mirq[0], tag, "irq (R9)", irq, mirq);
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin
         @(negedge clk);
         cnt_val = cnt_val + 1'b1;
      end
   endtask

   task automatic clear_all();
      flag_clr = '1;
      step();
      flag_clr = '0;
   endtask

   task automatic wander(int n, int prob);
      for (int j = 0; j < n; j++) begin
         step();
         for (int i = 0; i < NCH; i++)
            if ($urandom % prob == 0) cap_in[i] = ~cap_in[i];
         flag_clr = ($urandom % 25 == 0) ? NCH'($urandom) : '0;
      end
      flag_clr = '0;
   endtask

   initial begin : watchdog
      #(TCLK * 200000);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int t0;
      void'($urandom(7));
      step(3);
      rst_n = 1'b1;
      step();
      // R10: reset values
      chk(cap_flag == '0, "R10", "flags after reset", cap_flag, 0);
      chk(cap_val == '0, "R10", "capture after reset", cap_val, 0);
      chk(irq == 1'b0, "R10", "irq after reset", irq, 0);

      // R1: bypass latency
      tag = "R1";
      step(4);
      t0 = int'(cnt_val);
      cap_in[0] = 1'b1;
      step(3);
      chk(cap_flag[0] == 1'b0, "R1", "flag not yet set", cap_flag[0], 0);
      step();
      chk(cap_flag[0] == 1'b1, "R1", "flag at third edge", cap_flag[0], 1);
      chk(int'(cap_val[0 +: CW]) == t0 + 3, "R1", "captured count", cap_val[0 +: CW], t0 + 3);
      cap_in = '0;
      step(10);

      // R3 and R7: bus-clock codes, mixed edges
      tag = "R3";
      flt_code = {4'd0, 4'd3, 4'd2, 4'd1};
      edge_fall = 4'b0010;
      irq_en = 4'b0101;
      clear_all();
      wander(600, 6);
      cap_in = '0;
      step(20);
      clear_all();
      tag = "R7";
      cap_in[1] = 1'b1;
      step(20);
      chk(cap_flag[1] == 1'b0, "R7", "rising ignored on falling select", cap_flag[1], 0);
      cap_in[1] = 1'b0;
      step(20);
      chk(cap_flag[1] == 1'b1, "R7", "falling edge captured", cap_flag[1], 1);

      // R2: divider settings
      tag = "R2";
      flt_code = {4'd4, 4'd5, 4'd1, 4'd4};
      edge_fall = 4'b0000;
      irq_en = 4'b1111;
      for (int d = 1; d < 4; d++) begin
         div_sel = 2'(d);
         wander(800, 40);
      end
      div_sel = 2'b10;
      cap_in = '0;
      step(100);
      clear_all();
      cap_in[0] = 1'b1;
      step(30);
      cap_in[0] = 1'b0;
      step(60);
      chk(cap_flag[0] == 1'b0, "R2", "30-cycle pulse filtered at div 4", cap_flag[0], 0);
      cap_in[0] = 1'b1;
      step(60);
      chk(cap_flag[0] == 1'b1, "R2", "60-cycle level passes at div 4", cap_flag[0], 1);

      // R4: mid-range codes
      tag = "R4";
      div_sel = 2'b01;
      flt_code = {4'd9, 4'd8, 4'd7, 4'd6};
      edge_fall = 4'b1010;
      wander(5000, 150);
      flt_code = {4'd5, 4'd4, 4'd9, 4'd6};
      wander(3000, 120);

      // R5: slowest codes
      tag = "R5";
      div_sel = 2'b10;
      flt_code = {4'd15, 4'd14, 4'd13, 4'd12};
      edge_fall = 4'b0000;
      wander(30000, 1500);
      flt_code = {4'd11, 4'd10, 4'd15, 4'd13};
      wander(20000, 900);
      flt_code[3:0] = 4'd15;
      cap_in[0] = 1'b0;
      step(1200);
      clear_all();
      cap_in[0] = 1'b1;
      step(700);
      cap_in[0] = 1'b0;
      step(1200);
      chk(cap_flag[0] == 1'b0, "R5", "700-cycle pulse filtered at code 15", cap_flag[0], 0);
      cap_in[0] = 1'b1;
      step(1200);
      chk(cap_flag[0] == 1'b1, "R5", "long level passes at code 15", cap_flag[0], 1);

      // R6: run count restart
      tag = "R6";
      div_sel = 2'b00;
      flt_code = {4'd3, 4'd3, 4'd3, 4'd3};
      cap_in = '0;
      step(30);
      clear_all();
      for (int p = 0; p < 20; p++) begin
         cap_in[0] = 1'b1;
         step(7);
         cap_in[0] = 1'b0;
         step(3);
      end
      step(10);
      chk(cap_flag[0] == 1'b0, "R6", "7-sample pulses never pass need 8", cap_flag[0], 0);
      cap_in[0] = 1'b1;
      step(8);
      cap_in[0] = 1'b0;
      step(12);
      chk(cap_flag[0] == 1'b1, "R6", "8-sample pulse passes", cap_flag[0], 1);

      // R8: clear and set priority
      tag = "R8";
      flt_code = '0;
      cap_in = '0;
      step(10);
      clear_all();
      step(2);
      t0 = int'(cnt_val);
      cap_in[0] = 1'b1;
      step(3);
      flag_clr[0] = 1'b1;
      step();
      chk(cap_flag[0] == 1'b1, "R8", "capture beats clear", cap_flag[0], 1);
      chk(int'(cap_val[0 +: CW]) == t0 + 3, "R8", "value on contested cycle", cap_val[0 +: CW], t0 + 3);
      flag_clr[0] = 1'b0;
      step(5);
      chk(cap_flag[0] == 1'b1, "R8", "flag held", cap_flag[0], 1);
      chk(int'(cap_val[0 +: CW]) == t0 + 3, "R8", "capture held", cap_val[0 +: CW], t0 + 3);
      flag_clr[0] = 1'b1;
      step();
      flag_clr[0] = 1'b0;
      chk(cap_flag[0] == 1'b0, "R8", "flag cleared", cap_flag[0], 0);

      // R9: interrupt masking
      tag = "R9";
      cap_in = '0;
      step(5);
      cap_in[2] = 1'b1;
      irq_en = 4'b1011;
      step(6);
      chk(cap_flag[2] == 1'b1, "R9", "channel 2 flag set", cap_flag[2], 1);
      chk(irq == 1'b0, "R9", "masked flag keeps irq low", irq, 0);
      irq_en = 4'b0100;
      step();
      chk(irq == 1'b1, "R9", "enabled flag raises irq", irq, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule